// File: doc/BRIEF.md
# Programmable Baud-Rate Timer with Odd Division

This block divides the core clock down to a UART sampling clock. It is a down-counter that reloads from a programmable value n. Each time the counter passes zero, the divided output changes level, so one output period normally spans 2(n+1) input cycles. A "+1" count mode adds one cycle to the high half of each period. The period then becomes 2n+3, which gives odd division ratios. Once per full output period, a one-cycle underflow pulse is issued and a sticky flag is set. When that flag and an enable are both 1, an interrupt request is raised.

Software uses a byte-wide register bus to reach the block. The reload value occupies one byte address per byte, least significant byte at address 0. The control byte sits at the address just above the reload bytes. A new reload value is picked up only at the next reload, so a count already in progress is never shortened or lengthened. A clock-select bit is stored and can be read back, but only the internal clock drives the counter.

Top module: `baud_timer`

## Requirements
- R1: With control bit 7 at 0, the output `baud_clk` has a period of 2(n+1) cycles, with n+1 cycles low and n+1 cycles high, where n is the reload value.
- R2: With control bit 7 at 1, the period is 2n+3 cycles: the low half lasts n+1 cycles and the high half lasts n+2 cycles.
- R3: The following ratios are produced exactly: n=5 normal gives 12 cycles, n=25 in +1 mode gives 53 cycles, and n=60 normal gives 122 cycles.
- R4: After reset, the control byte (address 2) reads 0x00, the reload bytes (addresses 0 low, 1 high) read 0x00, and `baud_clk`, `uflow_pulse` and `irq` are 0.
- R5: Control bit 0 is run. While it is 0, the counter holds, `baud_clk` keeps its level and no underflow pulse occurs.
- R6: Writing 1 to control bit 1 reloads the counter from n and forces `baud_clk` low. This bit always reads 0.
- R7: `uflow_pulse` is high for exactly one cycle per output period. That cycle is the first cycle in which `baud_clk` is low again.
- R8: Control bit 3 is the underflow flag. It is set on each underflow pulse and stays set until a control write carries 0 in bit 3. A write of 1 in bit 3 changes nothing.
- R9: `irq` is 1 exactly when the flag (bit 3) and the interrupt enable (bit 4) are both 1.
- R10: A reload write made during a count does not change the half-period in progress. It applies from the next reload onward.
- R11: Control bits 6 and 5 always read 0. Bit 2, the clock select, reads back as written and has no effect on the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, counted directly |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe; data is returned on the next cycle |
| bus_addr | input | 2 | Byte address: 0/1 reload low/high, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| baud_clk | output | 1 | Divided output clock |
| uflow_pulse | output | 1 | One-cycle pulse once per output period |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
The hardest case to reach is a reload write that lands in the middle of a half-period. It has to arrive after the counter has loaded and well before the next zero crossing. To get there, the bench waits for a rising edge of `baud_clk` and issues the write a couple of cycles later. It then measures the rest of that half at the old length and the following half at the new length. The sticky-flag checks are also hard to isolate, because a fresh underflow would mask the effect of a write. For these checks the bench first stops the counter with a control write that preserves the flag, and only then probes write-1 and write-0.

// File: rtl/bt_pkg.sv
package bt_pkg;
  // Control byte layout; the field order is the bit order software sees.
  typedef struct packed {
    logic       plus_mode;  // bit 7
    logic [1:0] rsvd;       // bits 6:5
    logic       int_en;     // bit 4
    logic       uf_flag;    // bit 3
    logic       clk_sel;    // bit 2
    logic       clear;      // bit 1
    logic       run;        // bit 0
  } ctrl_t;
endpackage

// File: rtl/bt_regs.sv
module bt_regs
  import bt_pkg::*;
#(
  parameter int RLD_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              uf_evt,
  output logic [RLD_W-1:0]  reload,
  output logic              plus_mode,
  output logic              run,
  output logic              clr,
  output logic              irq
);
  localparam int NBYTES = RLD_W / 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NBYTES);

  ctrl_t wr_c;
  logic  wr_ctrl;
  logic  plus_q, ie_q, uf_q, cs_q, run_q, irq_q;
  logic  ie_d, uf_d;
  logic  unused_rsvd;
  logic [RLD_W-1:0] rld_q;
  logic [7:0]       rd_mux, rdata_q;

  assign wr_c        = ctrl_t'(bus_wdata);
  assign wr_ctrl     = bus_wr && (bus_addr == CTRL_ADDR);
  assign unused_rsvd = ^wr_c.rsvd;

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_rld
      always_ff @(posedge clk) begin
        if (rst)
          rld_q[8*g +: 8] <= '0;
        else if (bus_wr && bus_addr == ADDR_W'(g))
          rld_q[8*g +: 8] <= bus_wdata;
      end
    end
  endgenerate

  always_comb begin
    ie_d = wr_ctrl ? wr_c.int_en : ie_q;
    if (uf_evt)                       uf_d = 1'b1;
    else if (wr_ctrl && !wr_c.uf_flag) uf_d = 1'b0;
    else                               uf_d = uf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      plus_q <= 1'b0; ie_q <= 1'b0; uf_q <= 1'b0;
      cs_q   <= 1'b0; run_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        plus_q <= wr_c.plus_mode;
        cs_q   <= wr_c.clk_sel;
        run_q  <= wr_c.run;
      end
      ie_q  <= ie_d;
      uf_q  <= uf_d;
      irq_q <= uf_d & ie_d;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (bus_addr == CTRL_ADDR)
      rd_mux = {plus_q, 2'b00, ie_q, uf_q, cs_q, 1'b0, run_q};
    else
      for (int i = 0; i < NBYTES; i++)
        if (bus_addr == ADDR_W'(i)) rd_mux = rld_q[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= 8'h00;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign reload    = rld_q;
  assign plus_mode = plus_q;
  assign run       = run_q;
  assign clr       = wr_ctrl && wr_c.clear;
  assign irq       = irq_q;

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (uf_q && ie_q));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (uf_q && !(wr_ctrl && !wr_c.uf_flag)) |=> uf_q);

  assert_flag_sets_R8: assert property (@(posedge clk) disable iff (rst)
    uf_evt |=> uf_q);

  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == CTRL_ADDR) |=> (bus_rdata[6:5] == 2'b00 && !bus_rdata[1]));
endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int RLD_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RLD_W-1:0] reload,
  input  logic             plus_mode,
  input  logic             run,
  input  logic             clr,
  output logic             baud_clk,
  output logic             uf_pulse
);
  logic [RLD_W-1:0] cnt_q;
  logic             baud_q, hold_q, pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0; baud_q <= 1'b0; hold_q <= 1'b0; pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (clr) begin
        cnt_q  <= reload;
        baud_q <= 1'b0;
        hold_q <= 1'b0;
      end else if (run) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (plus_mode && baud_q && !hold_q) begin
          hold_q <= 1'b1;            // stretch the high half by one cycle
        end else begin
          cnt_q   <= reload;         // new n is sampled only here
          baud_q  <= ~baud_q;
          hold_q  <= 1'b0;
          pulse_q <= baud_q;         // one pulse per period, at the fall
        end
      end
    end
  end

  assign baud_clk = baud_q;
  assign uf_pulse = pulse_q;

  assert_halt_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> ($stable(baud_q) && !pulse_q));

  assert_pulse_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> ($fell(baud_q)));

  assert_clear_lowers_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!baud_q && !pulse_q));

  assert_stretch_plus_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_q) |-> ($past(plus_mode) && baud_q));
endmodule

// File: rtl/baud_timer.sv
module baud_timer #(
  parameter int RLD_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              baud_clk,
  output logic              uflow_pulse,
  output logic              irq
);
  logic [RLD_W-1:0] reload;
  logic             plus_mode, run, clr, uf_evt;

  bt_regs #(.RLD_W(RLD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .uf_evt(uf_evt), .reload(reload), .plus_mode(plus_mode),
    .run(run), .clr(clr), .irq(irq)
  );

  bt_counter #(.RLD_W(RLD_W)) u_cnt (
    .clk(clk), .rst(rst), .reload(reload), .plus_mode(plus_mode),
    .run(run), .clr(clr), .baud_clk(baud_clk), .uf_pulse(uf_evt)
  );

  assign uflow_pulse = uf_evt;
endmodule

// File: tb/baud_timer_bench.sv
module baud_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       baud_clk, uflow_pulse, irq;

  int total = 0, bad = 0, cyc = 0, pcnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  baud_timer u_baud_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .baud_clk(baud_clk), .uflow_pulse(uflow_pulse), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (uflow_pulse) pcnt <= pcnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_edge(input logic lvl, output int t);
    logic p;
    do begin p = baud_clk; @(negedge clk); end while (!(baud_clk == lvl && p != lvl));
    t = cyc;
  endtask

  // start from a clean phase, then measure one full period
  task automatic measure(input int n, input bit plus, input bit cs, input string req);
    int r1, f1, r2, p1;
    wr(2'd0, n[7:0]); wr(2'd1, n[15:8]);
    wr(2'd2, {plus, 4'b0000, cs, 2'b11});
    wait_edge(1'b1, r1); p1 = pcnt;
    wait_edge(1'b0, f1);
    wait_edge(1'b1, r2);
    check({req, " high"},   f1 - r1, n + 1 + int'(plus));
    check({req, " low"},    r2 - f1, n + 1);
    check({req, " period"}, r2 - r1, plus ? 2*n + 3 : 2*n + 2);
    check("R7 pulses per period", pcnt - p1, 1);
  endtask

  initial begin
    logic [7:0] d;
    int t0, t1, t2, p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R4 reset state
    check("R4 baud_clk", int'(baud_clk), 0);
    check("R4 irq", int'(irq), 0);
    check("R4 uflow_pulse", int'(uflow_pulse), 0);
    rd(2'd2, d); check("R4 ctrl", int'(d), 0);
    rd(2'd0, d); check("R4 reload lo", int'(d), 0);
    rd(2'd1, d); check("R4 reload hi", int'(d), 0);

    // R1/R2 sweep of small n in both modes
    for (int n = 0; n < 16; n++) begin
      measure(n, 1'b0, 1'b0, "R1");
      measure(n, 1'b1, 1'b0, "R2");
    end
    // R3 required ratios
    measure(5, 1'b0, 1'b0, "R3 n5");
    measure(25, 1'b1, 1'b0, "R3 n25");
    measure(60, 1'b0, 1'b0, "R3 n60");
    measure(300, 1'b0, 1'b0, "R1 n300");

    // R11 reserved bits read 0, clock select stored, no effect
    wr(2'd2, 8'h64); rd(2'd2, d); check("R11 ctrl readback", int'(d), 8'h04);
    measure(7, 1'b0, 1'b1, "R11 clksel");

    // R6 clear bit reads 0 and forces output low
    wr(2'd2, 8'h03); rd(2'd2, d); check("R6 clear reads 0", int'(d[1]), 0);
    wait_edge(1'b1, t0);
    wr(2'd2, 8'h03); check("R6 output low after clear", int'(baud_clk), 0);

    // R5 halt: output frozen, no pulses
    wr(2'd2, 8'h00);
    @(negedge clk); d[0] = baud_clk; p0 = pcnt;
    repeat (60) @(negedge clk);
    check("R5 level held", int'(baud_clk), int'(d[0]));
    check("R5 no pulses", pcnt - p0, 0);

    // R10 reload change during a count
    wr(2'd0, 8'd10); wr(2'd1, 8'd0); wr(2'd2, 8'h03);
    wait_edge(1'b1, t0);
    wr(2'd0, 8'd3);
    wait_edge(1'b0, t1);
    wait_edge(1'b1, t2);
    check("R10 old half kept", t1 - t0, 11);
    check("R10 new half used", t2 - t1, 4);

    // R8/R9 sticky flag and interrupt
    wait_edge(1'b0, t0); @(negedge clk);
    rd(2'd2, d); check("R8 flag set", int'(d[3]), 1);
    check("R9 irq off while disabled", int'(irq), 0);
    wr(2'd2, 8'h18);                    // stop, keep flag, enable irq
    rd(2'd2, d); check("R8 flag kept", int'(d), 8'h18);
    check("R9 irq on", int'(irq), 1);
    wr(2'd2, 8'h08);
    check("R9 irq off with enable 0", int'(irq), 0);
    rd(2'd2, d); check("R8 flag still set", int'(d[3]), 1);
    wr(2'd2, 8'h10);
    rd(2'd2, d); check("R8 write 0 clears", int'(d), 8'h10);
    check("R9 irq off flag 0", int'(irq), 0);
    wr(2'd2, 8'h18);
    rd(2'd2, d); check("R8 write 1 no effect", int'(d), 8'h10);
    check("R9 irq stays off", int'(irq), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule